// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small processor core with one accumulator. It runs a fixed fetch-then-execute loop against a word-addressed, single-ported memory. Every instruction is one 16-bit word. The top four bits select the operation. The low twelve bits give a direct memory address. The core has four operations on the accumulator: load it, add a memory word to it, store it, and halt. It also has a return-from-interrupt operation. Any other code is treated as a fault. Every memory transfer passes through a memory address register and a memory buffer register. Fetched words pass through the instruction register.

An interrupt is sampled only between instructions, after an execute step and before the next fetch. When an interrupt is taken, the core saves the program counter in a shadow register and continues fetching at a fixed handler address. Further requests are ignored until the handler returns. Execution continues until a halt word or an undefined code stops the core. The core is meant for small controllers and for checking a memory system.

Top module: `acc_core`

## Requirements
- R1: An instruction word has the opcode in bits 15:12 and the operand address in bits 11:0. A fetch reads the word at the program counter, and the program counter advances by exactly one after every fetch. Instructions therefore run from consecutive addresses.
- R2: After reset the accumulator is 0, `halted` and `error` are low, and the first memory read is the instruction fetch at `START_ADDR`.
- R3: Opcode 0x1 replaces the accumulator with the memory word at the operand address.
- R4: Opcode 0x5 adds the memory word at the operand address to the accumulator. The 16-bit sum wraps modulo 2^16.
- R5: Opcode 0x2 performs exactly one memory write: the accumulator value goes to the operand address.
- R6: Opcode 0xF raises `halted`. From then on there is no memory read or write, and `halted` stays high until reset.
- R7: Any opcode other than 0x1, 0x2, 0x5, 0xE and 0xF raises both `error` and `halted`, and no further memory access follows.
- R8: The memory port has a one-cycle read latency: `mem_rdata` is taken in the cycle after `mem_re`. `mem_re` and `mem_we` are never high in the same cycle.
- R9: If `irq` is high when an instruction finishes, the next fetch comes from `HANDLER_ADDR` (default 0xFF0) and not from the next program address.
- R10: While the handler runs, `irq` is ignored. Opcode 0xE resumes the interrupted program at the address that follows the last instruction it completed. The accumulator is unchanged by entering or leaving the handler.
- R11: While `irq` stays low, a program of loads, adds and stores leaves the accumulator and memory exactly as sequential execution of its instructions would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Pending-interrupt request, level sensitive |
| mem_addr | output | 12 | Memory word address (from the address register) |
| mem_re | output | 1 | Read request; data is returned one cycle later |
| mem_we | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data (from the buffer register) |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| acc_out | output | 16 | Current accumulator value |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on an undefined opcode |

## Verification
The bench uses the default parameters: a 16-bit word, a 12-bit address, a start address of 0x300 and a handler at 0xFF0. With these values the handler sits near the top of the address space, so the twelve-bit operand field can reach every word the bench uses. The full-width adder is wide enough to show wrap-around with 0xFFFF operands. Random load/add/store programs over a sixteen-word data window produce repeated stores and reloads to the same address. An interrupt raised during the first instruction and held high through the handler shows both the diversion and the suppression of nested requests in the recorded read-address trace.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Opcode values are decoded from the top nibble of the instruction word
    localparam logic [3:0] OPC_LOAD  = 4'h1;
    localparam logic [3:0] OPC_STORE = 4'h2;
    localparam logic [3:0] OPC_ADD   = 4'h5;
    localparam logic [3:0] OPC_RETI  = 4'hE;
    localparam logic [3:0] OPC_STOP  = 4'hF;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_ADD,
        K_STOP,
        K_RETI,
        K_BAD
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_FETCH,    // address register <- program counter
        ST_FREAD,    // instruction read issued
        ST_FLATCH,   // instruction word captured, program counter advances
        ST_DECODE,   // decide the operand transfer
        ST_OREAD,    // operand read issued
        ST_EXEC,     // operand captured, accumulator updated
        ST_OWRITE,   // accumulator written to memory
        ST_IRQCHK,   // interrupt test between instructions
        ST_STOPPED
    } core_state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 12
) (
    input  logic [DW-1:0] instr,
    output op_kind_e      kind,
    output logic [AW-1:0] operand_addr
);
    localparam int unsigned OPW = DW - AW;

    logic [OPW-1:0] opc;

    assign opc          = instr[DW-1:AW];
    assign operand_addr = instr[AW-1:0];

    always_comb begin
        unique case (opc)
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_ADD:   kind = K_ADD;
            OPC_RETI:  kind = K_RETI;
            OPC_STOP:  kind = K_STOP;
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  op_kind_e      kind,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result
);
    logic [DW-1:0] sum;

    assign sum = acc + operand;

    always_comb begin
        if (kind == K_LOAD) result = operand;
        else if (kind == K_ADD) result = sum;
        else result = acc;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int unsigned DW           = 16,
    parameter int unsigned AW           = 12,
    parameter int unsigned START_ADDR   = 'h300,
    parameter int unsigned HANDLER_ADDR = 'hFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_out,
    output logic          halted,
    output logic          error
);
    localparam logic [AW-1:0] PC_RESET = AW'(START_ADDR);
    localparam logic [AW-1:0] PC_VEC   = AW'(HANDLER_ADDR);
    localparam logic [AW-1:0] PC_STEP  = AW'(1);

    typedef struct packed {
        core_state_e   state;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] acc;
        logic [AW-1:0] shadow;
        logic          in_isr;
        logic          halted;
        logic          error;
    } core_regs_t;

    core_regs_t r_d, r_q;

    op_kind_e      dec_kind;
    logic [AW-1:0] dec_addr;
    logic [DW-1:0] alu_res;

    acc_decode #(.DW(DW), .AW(AW)) u_decode (
        .instr        (r_q.ir),
        .kind         (dec_kind),
        .operand_addr (dec_addr)
    );

    acc_alu #(.DW(DW)) u_alu (
        .kind    (dec_kind),
        .acc     (r_q.acc),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    always_comb begin
        r_d    = r_q;
        mem_re = 1'b0;
        mem_we = 1'b0;
        unique case (r_q.state)
            ST_FETCH: begin
                r_d.mar   = r_q.pc;
                r_d.state = ST_FREAD;
            end
            ST_FREAD: begin
                mem_re    = 1'b1;
                r_d.state = ST_FLATCH;
            end
            ST_FLATCH: begin
                r_d.mbr   = mem_rdata;
                r_d.ir    = mem_rdata;
                r_d.pc    = r_q.pc + PC_STEP;
                r_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                unique case (dec_kind)
                    K_LOAD, K_ADD: begin
                        r_d.mar   = dec_addr;
                        r_d.state = ST_OREAD;
                    end
                    K_STORE: begin
                        r_d.mar   = dec_addr;
                        r_d.mbr   = r_q.acc;
                        r_d.state = ST_OWRITE;
                    end
                    K_RETI: begin
                        r_d.pc     = r_q.shadow;
                        r_d.in_isr = 1'b0;
                        r_d.state  = ST_IRQCHK;
                    end
                    K_STOP: begin
                        r_d.halted = 1'b1;
                        r_d.state  = ST_STOPPED;
                    end
                    default: begin
                        r_d.error  = 1'b1;
                        r_d.halted = 1'b1;
                        r_d.state  = ST_STOPPED;
                    end
                endcase
            end
            ST_OREAD: begin
                mem_re    = 1'b1;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.mbr   = mem_rdata;
                r_d.acc   = alu_res;
                r_d.state = ST_IRQCHK;
            end
            ST_OWRITE: begin
                mem_we    = 1'b1;
                r_d.state = ST_IRQCHK;
            end
            ST_IRQCHK: begin
                if (irq && !r_q.in_isr) begin
                    r_d.shadow = r_q.pc;
                    r_d.pc     = PC_VEC;
                    r_d.in_isr = 1'b1;
                end
                r_d.state = ST_FETCH;
            end
            default: begin
                r_d.state = ST_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_FETCH;
            r_q.pc     <= PC_RESET;
            r_q.ir     <= '0;
            r_q.mar    <= '0;
            r_q.mbr    <= '0;
            r_q.acc    <= '0;
            r_q.shadow <= '0;
            r_q.in_isr <= 1'b0;
            r_q.halted <= 1'b0;
            r_q.error  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mbr;
    assign acc_out   = r_q.acc;
    assign halted    = r_q.halted;
    assign error     = r_q.error;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));  // R8

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_FLATCH |=> r_q.pc == $past(r_q.pc) + PC_STEP);  // R1

    AST_STORE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata == r_q.acc);  // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !mem_re && !mem_we);  // R6

    AST_ERROR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);  // R7

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IRQCHK && irq && !r_q.in_isr) |=> (r_q.pc == PC_VEC && r_q.in_isr));  // R9

    AST_NO_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.in_isr |=> $stable(r_q.shadow));  // R10

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
    localparam int DW = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] acc_out;
    logic          halted, error;

    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int n_checks = 0;
    int n_errors = 0;
    int rd_log [0:63];
    int rd_cnt;
    int post_acc;
    bit irq_mode;

    always #5 clk = ~clk;

    acc_core #(.DW(DW), .AW(AW), .START_ADDR('h300), .HANDLER_ADDR('hFF0)) u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .halted(halted), .error(error)
    );

    // memory model: one-cycle read latency, preload port used while in reset
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic begin_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq = 1'b0;
    endtask

    task automatic end_reset_check();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_out == 16'h0, "R2", "accumulator after reset", int'(acc_out), 0);
        chk(!halted && !error, "R2", "status after reset", int'({halted, error}), 0);
    endtask

    // runs until halted, logging read addresses; afterwards counts idle-time accesses
    task automatic run_prog();
        rd_cnt = 0;
        post_acc = 0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            if (mem_re) begin
                if (rd_cnt < 64) rd_log[rd_cnt] = int'(mem_addr);
                rd_cnt++;
                if (irq_mode && mem_addr == 12'h300) irq = 1'b1;
                if (irq_mode && mem_addr == 12'hFF1) irq = 1'b0;
            end
            if (halted) break;
            @(negedge clk);
        end
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_re || mem_we) post_acc++;
        end
    endtask

    task automatic check_trace(input string req, input int exp_list[], input int n);
        chk(rd_cnt == n, req, "read count", rd_cnt, n);
        for (int i = 0; i < n && i < rd_cnt; i++)
            chk(rd_log[i] == exp_list[i], req, "read address order", rd_log[i], exp_list[i]);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    initial begin
        int exp_tr [];
        logic [15:0] ref_mem [0:15];
        logic [15:0] ref_acc;
        logic [15:0] prog [0:8];
        void'($urandom(32'h5EED_0042));
        irq_mode = 0;

        // directed: the add-two-words example (R1, R3, R4, R5)
        begin_reset();
        poke('h300, 16'h1940); poke('h301, 16'h5941);
        poke('h302, 16'h2941); poke('h303, 16'hF000);
        poke('h940, 16'h0003); poke('h941, 16'h0002);
        end_reset_check();
        run_prog();
        exp_tr = '{'h300, 'h940, 'h301, 'h941, 'h302, 'h303};
        check_trace("R1", exp_tr, 6);
        chk(rd_log[0] == 'h300, "R2", "first fetch address", rd_log[0], 'h300);
        chk(mem['h941] == 16'h0005, "R5", "stored sum", int'(mem['h941]), 5);
        chk(acc_out == 16'h0005, "R4", "accumulator sum", int'(acc_out), 5);
        chk(mem['h940] == 16'h0003, "R3", "load source untouched", int'(mem['h940]), 3);
        chk(halted && !error, "R6", "halt flags", int'({halted, error}), 2);
        chk(post_acc == 0, "R6", "accesses after halt", post_acc, 0);

        // directed: adder wrap (R4)
        begin_reset();
        poke('h300, 16'h1940); poke('h301, 16'h5941); poke('h302, 16'hF000);
        poke('h940, 16'hFFFF); poke('h941, 16'h0003);
        end_reset_check();
        run_prog();
        chk(acc_out == 16'h0002, "R4", "wrapped sum", int'(acc_out), 2);

        // directed: undefined opcode (R7)
        begin_reset();
        poke('h300, 16'h7123);
        end_reset_check();
        run_prog();
        chk(error && halted, "R7", "fault flags", int'({halted, error}), 3);
        chk(rd_cnt == 1, "R7", "reads before fault stop", rd_cnt, 1);
        chk(post_acc == 0, "R7", "accesses after fault", post_acc, 0);

        // directed: interrupt during first instruction, held through handler (R9, R10)
        begin_reset();
        poke('h300, 16'h1940); poke('h301, 16'h5941);
        poke('h302, 16'h2941); poke('h303, 16'hF000);
        poke('h940, 16'h0011); poke('h941, 16'h0022);
        poke('hFF0, 16'h2950); poke('hFF1, 16'hE000);
        poke('h950, 16'h0000);
        irq_mode = 1;
        end_reset_check();
        run_prog();
        irq_mode = 0;
        irq = 1'b0;
        exp_tr = '{'h300, 'h940, 'hFF0, 'hFF1, 'h301, 'h941, 'h302, 'h303};
        check_trace("R9", exp_tr, 8);
        chk(mem['h950] == 16'h0011, "R10", "handler saw accumulator", int'(mem['h950]), 'h11);
        chk(mem['h941] == 16'h0033, "R10", "program resumed result", int'(mem['h941]), 'h33);
        chk(!error, "R10", "no fault on return", int'(error), 0);

        // random programs with irq low (R11, R3, R4, R5)
        for (int t = 0; t < 25; t++) begin
            int n;
            n = 1 + int'($urandom % 8);
            begin_reset();
            for (int i = 0; i < 16; i++) begin
                ref_mem[i] = 16'($urandom);
                if (t % 5 == 0) ref_mem[i] = 16'hFFF0 | 16'(i);
                poke('h800 + i, int'(ref_mem[i]));
            end
            for (int i = 0; i < n; i++) begin
                int sel;
                sel = int'($urandom % 3);
                prog[i] = mk(sel == 0 ? 4'h1 : (sel == 1 ? 4'h5 : 4'h2),
                             12'h800 + 12'($urandom % 16));
                poke('h300 + i, int'(prog[i]));
            end
            poke('h300 + n, 16'hF000);
            end_reset_check();
            run_prog();
            ref_acc = '0;
            for (int i = 0; i < n; i++) begin
                int a;
                a = int'(prog[i][3:0]);
                case (prog[i][15:12])
                    4'h1: ref_acc = ref_mem[a];
                    4'h5: ref_acc = ref_acc + ref_mem[a];
                    default: ref_mem[a] = ref_acc;
                endcase
            end
            chk(acc_out == ref_acc, "R11", "random program accumulator",
                int'(acc_out), int'(ref_acc));
            begin
                int bad, first;
                bad = 0; first = 0;
                for (int i = 0; i < 16; i++)
                    if (mem['h800 + i] !== ref_mem[i]) begin
                        if (bad == 0) first = i;
                        bad++;
                    end
                chk(bad == 0, "R11", "random program memory word",
                    int'(mem['h800 + first]), int'(ref_mem[first]));
            end
            chk(rd_log[0] == 'h300 && halted && !error, "R1", "random run start/stop",
                rd_log[0], 'h300);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule